// File: doc/BRIEF.md
# Quasi-Cyclic Systematic Code Encoder

This block encodes one message at a time with a quasi-cyclic code whose generator matrix is systematic and has two circulant blocks. The public key is a single polynomial of R bits. It serves as the first row of the redundant block of the generator matrix. Every later row is that polynomial rotated by one more position. The row is produced on the fly in a row register, so no matrix is stored. Message bits arrive one per beat and pass straight through as the systematic half of the ciphertext. For each message bit that is 1, the current row is folded into an R-bit redundancy accumulator. Once the last message bit has gone out, the accumulator is shifted out as the second half.

The environment supplies the error vector. It can load the vector in parallel when a message starts, stream it one bit per output beat, or do both. The two sources are XORed together. Random error generation, key generation and any conversion layer sit outside the block.

Both data streams use valid/ready. While the systematic half is in flight, the message stream is joined to the ciphertext stream without any buffer between them. `msg_ready` follows `ct_ready`, and `ct_valid` follows `msg_valid`. An upstream stall or a downstream stall therefore holds both sides. While the redundancy half is in flight, `ct_valid` stays high and `ct_bit` holds its value until the beat is taken. The `start`, `key_load`, `busy` and `done` pins are plain level and pulse signals.

Top module: `qc_sys_encoder`

## Requirements
- R1: After reset, `busy`, `done`, `ct_valid` and `msg_ready` are all 0. While `busy` is 0, `ct_valid` and `msg_ready` stay 0.
- R2: A `key_load` pulse while `busy` is 0 stores `key_in` as the public polynomial, and that polynomial is used by the next message. A `key_load` while `busy` is 1 has no effect on the current message or on later messages.
- R3: A `start` pulse while `busy` is 0 does four things. It clears the redundancy accumulator, loads the row from the stored key, latches `err_vec`, and raises `busy` on the following cycle. `ct_first` is 1 on the first ciphertext beat and on no other beat.
- R4: Ciphertext beats 0 to R-1 carry the message bits in order, XORed with the error bits. While these beats are in flight, `msg_ready` equals `ct_ready`, and a message bit is accepted exactly when a ciphertext beat is taken.
- R5: Ciphertext beat R+j carries redundancy bit j. Redundancy bit j equals the XOR, over all message bits k, of m[k] AND key[(j+k) mod R], XORed with the error bits. Row k+1 is row k rotated right by one position, so that row bit j takes the old bit j+1, and row bit R-1 takes the old bit 0.
- R6: Once the systematic half is done, `ct_valid` stays 1 through all R redundancy beats. `ct_bit` does not change while `ct_ready` is 0.
- R7: Ciphertext beat i is XORed with `err_vec[i]` as latched at start, and with `err_bit` as sampled on the same beat.
- R8: `ct_last` is 1 only on beat 2R-1. After that beat is taken, `busy` falls and `done` is 1. `done` stays 1 until the next accepted start, which clears it.
- R9: While `busy` is 1, a `start` pulse has no effect. The running message, its latched error vector and its key are kept.
- R10: With `msg_valid` and `ct_ready` held high, the message is taken in exactly R cycles and the whole ciphertext in exactly 2R cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_load | input | 1 | Store `key_in` as the public polynomial (taken only while idle) |
| key_in | input | R | Public polynomial |
| start | input | 1 | Begin a message (taken only while idle) |
| err_vec | input | 2R | Parallel error vector, latched at start, bit i for beat i |
| busy | output | 1 | A message is being encoded |
| done | output | 1 | The last ciphertext beat of the previous message has been taken |
| msg_valid | input | 1 | Message bit valid |
| msg_ready | output | 1 | Message bit accepted this cycle if valid |
| msg_bit | input | 1 | Message bit |
| err_bit | input | 1 | Streamed error bit for the current ciphertext beat |
| ct_valid | output | 1 | Ciphertext bit valid |
| ct_ready | input | 1 | Downstream accepts the ciphertext bit |
| ct_bit | output | 1 | Ciphertext bit |
| ct_first | output | 1 | Marks ciphertext beat 0 |
| ct_last | output | 1 | Marks ciphertext beat 2R-1 |

## Verification
The hardest situations to reach are the two half boundaries under back-pressure. The first is when the R-th rotation brings the row back to the key at the same moment the block switches to the redundancy half. The second is when a start or key load arrives in the middle of a message while the downstream side is stalled. The bench uses an odd R of 13 so that rotation indices do not align with powers of two. It runs messages with random gaps in both `msg_valid` and `ct_ready`. In one run it pulses `start` and `key_load` with altered key and error inputs a few cycles in. It checks every presented bit, stalled ones included, against an expected ciphertext that a bench function computes from the row formula.

// File: rtl/qcenc_pkg.sv
package qcenc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYS  = 2'd1,
    PH_RED  = 2'd2
  } qc_phase_e;
endpackage

// File: rtl/qcenc_ctrl.sv
module qcenc_ctrl
  import qcenc_pkg::*;
#(
  parameter int R = 4800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic msg_valid,
  input  logic ct_ready,
  output logic launch,
  output logic in_sys,
  output logic sys_beat,
  output logic red_beat,
  output logic sys_wrap,
  output logic red_wrap,
  output logic msg_ready,
  output logic ct_valid,
  output logic ct_first,
  output logic ct_last,
  output logic busy,
  output logic done
);
  localparam int CW = (R > 1) ? $clog2(R) : 1;
  localparam logic [CW-1:0] LAST = CW'(R - 1);

  qc_phase_e     phase_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          at_end;

  assign at_end    = (cnt_q == LAST);
  assign in_sys    = (phase_q == PH_SYS);
  assign busy      = (phase_q != PH_IDLE);
  assign done      = done_q;
  assign launch    = start && (phase_q == PH_IDLE);
  assign msg_ready = in_sys && ct_ready;
  assign ct_valid  = (in_sys && msg_valid) || (phase_q == PH_RED);
  assign sys_beat  = in_sys && msg_valid && ct_ready;
  assign red_beat  = (phase_q == PH_RED) && ct_ready;
  assign sys_wrap  = sys_beat && at_end;
  assign red_wrap  = red_beat && at_end;
  assign ct_first  = in_sys && (cnt_q == '0);
  assign ct_last   = (phase_q == PH_RED) && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (launch) begin
      phase_q <= PH_SYS;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (sys_beat) begin
      if (at_end) begin
        phase_q <= PH_RED;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end else if (red_beat) begin
      if (at_end) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
        done_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R1: an idle block presents nothing and accepts nothing
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ct_valid && !msg_ready));

  // R8: taking the final beat ends the message and raises done
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_valid && ct_ready && ct_last) |=> (done && !busy));

  // R9: start during a message does not end or restart it
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(ct_last && ct_ready) && !done) |=> (busy && !done));

  // R6: a stalled redundancy beat stays presented
  p_red_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_RED) && !ct_ready) |=> (ct_valid && $stable(cnt_q)));
endmodule

// File: rtl/qcenc_row.sv
module qcenc_row #(
  parameter int R = 4800
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         key_load,
  input  logic [R-1:0] key_in,
  input  logic         busy,
  input  logic         launch,
  input  logic         step,
  input  logic         wrap,
  output logic [R-1:0] row
);
  logic [R-1:0] key_q;
  logic [R-1:0] key_next;
  logic [R-1:0] row_q;

  assign key_next = (key_load && !busy) ? key_in : key_q;
  assign row      = row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q <= '0;
      row_q <= '0;
    end else begin
      key_q <= key_next;
      if (launch) begin
        row_q <= key_next;
      end else if (step) begin
        row_q <= {row_q[0], row_q[R-1:1]};
      end
    end
  end

  // R5: R single-step rotations bring the row back to the stored key
  p_row_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (row_q == key_q));

  // R2: the stored key cannot change while a message runs
  p_key_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(key_q));
endmodule

// File: rtl/qcenc_acc.sv
module qcenc_acc #(
  parameter int R = 4800
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch,
  input  logic         sys_beat,
  input  logic         msg_bit,
  input  logic [R-1:0] row,
  input  logic         red_beat,
  output logic         red_bit
);
  logic [R-1:0] acc_q;

  assign red_bit = acc_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (launch) begin
      acc_q <= '0;
    end else if (sys_beat) begin
      if (msg_bit) begin
        acc_q <= acc_q ^ row;
      end
    end else if (red_beat) begin
      acc_q <= {1'b0, acc_q[R-1:1]};
    end
  end

  // R5: the accumulator only moves on a launch or a taken beat
  p_acc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch || sys_beat || red_beat) |=> $stable(acc_q));
endmodule

// File: rtl/qcenc_err.sv
module qcenc_err #(
  parameter int R = 4800
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           launch,
  input  logic [2*R-1:0] err_vec,
  input  logic           beat,
  input  logic           finish,
  output logic           err_head
);
  localparam int N = 2 * R;

  logic [N-1:0] err_q;

  assign err_head = err_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= '0;
    end else if (launch) begin
      err_q <= err_vec;
    end else if (beat) begin
      err_q <= {1'b0, err_q[N-1:1]};
    end
  end

  // R7: every latched error bit has been applied once the last beat is taken
  p_err_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (err_q == '0));
endmodule

// File: rtl/qc_sys_encoder.sv
module qc_sys_encoder #(
  parameter int R = 4800
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           key_load,
  input  logic [R-1:0]   key_in,
  input  logic           start,
  input  logic [2*R-1:0] err_vec,
  output logic           busy,
  output logic           done,
  input  logic           msg_valid,
  output logic           msg_ready,
  input  logic           msg_bit,
  input  logic           err_bit,
  output logic           ct_valid,
  input  logic           ct_ready,
  output logic           ct_bit,
  output logic           ct_first,
  output logic           ct_last
);
  logic         launch;
  logic         in_sys;
  logic         sys_beat;
  logic         red_beat;
  logic         sys_wrap;
  logic         red_wrap;
  logic [R-1:0] row;
  logic         red_bit;
  logic         err_head;
  logic         code_bit;

  qcenc_ctrl #(.R(R)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .msg_valid (msg_valid),
    .ct_ready  (ct_ready),
    .launch    (launch),
    .in_sys    (in_sys),
    .sys_beat  (sys_beat),
    .red_beat  (red_beat),
    .sys_wrap  (sys_wrap),
    .red_wrap  (red_wrap),
    .msg_ready (msg_ready),
    .ct_valid  (ct_valid),
    .ct_first  (ct_first),
    .ct_last   (ct_last),
    .busy      (busy),
    .done      (done)
  );

  qcenc_row #(.R(R)) u_row (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_load (key_load),
    .key_in   (key_in),
    .busy     (busy),
    .launch   (launch),
    .step     (sys_beat),
    .wrap     (sys_wrap),
    .row      (row)
  );

  qcenc_acc #(.R(R)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .sys_beat (sys_beat),
    .msg_bit  (msg_bit),
    .row      (row),
    .red_beat (red_beat),
    .red_bit  (red_bit)
  );

  qcenc_err #(.R(R)) u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .err_vec  (err_vec),
    .beat     (sys_beat || red_beat),
    .finish   (red_wrap),
    .err_head (err_head)
  );

  assign code_bit = in_sys ? msg_bit : red_bit;
  assign ct_bit   = code_bit ^ err_head ^ err_bit;

  // R4: in the systematic half a message bit is taken exactly with a ciphertext beat
  p_pass_lockstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sys && ct_valid) |-> (msg_valid && (msg_ready == ct_ready)));
endmodule

// File: tb/qc_sys_encoder_bench.sv
module qc_sys_encoder_bench;
  localparam int R = 13;
  localparam int N = 2 * R;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           key_load;
  logic [R-1:0]   key_in;
  logic           start;
  logic [N-1:0]   err_vec;
  logic           busy;
  logic           done;
  logic           msg_valid;
  logic           msg_ready;
  logic           msg_bit;
  logic           err_bit;
  logic           ct_valid;
  logic           ct_ready;
  logic           ct_bit;
  logic           ct_first;
  logic           ct_last;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [R-1:0] cur_key;

  always #5 clk = ~clk;

  qc_sys_encoder #(.R(R)) u_qc_sys_encoder (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
    .start(start), .err_vec(err_vec), .busy(busy), .done(done),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_bit(msg_bit),
    .err_bit(err_bit), .ct_valid(ct_valid), .ct_ready(ct_ready),
    .ct_bit(ct_bit), .ct_first(ct_first), .ct_last(ct_last)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] expect_ct(input logic [R-1:0] k,
      input logic [R-1:0] m, input logic [N-1:0] ev, input logic [N-1:0] es);
    logic [N-1:0] o;
    for (int i = 0; i < R; i++) o[i] = m[i] ^ ev[i] ^ es[i];
    for (int j = 0; j < R; j++) begin
      logic b;
      b = 1'b0;
      for (int kk = 0; kk < R; kk++)
        if (m[kk]) b = b ^ k[(j + kk) % R];
      o[R + j] = b ^ ev[R + j] ^ es[R + j];
    end
    return o;
  endfunction

  function automatic logic [R-1:0] rnd_r();
    return R'($urandom());
  endfunction

  function automatic logic [N-1:0] rnd_n();
    return N'($urandom());
  endfunction

  task automatic load_key(input logic [R-1:0] k);
    @(negedge clk);
    key_in = k;
    key_load = 1'b1;
    @(negedge clk);
    key_load = 1'b0;
    cur_key = k;
  endtask

  task automatic run_msg(input logic [R-1:0] m, input logic [N-1:0] ev,
      input logic [N-1:0] es, input int vprob, input int rprob, input bit poke,
      output int cycles);
    logic [N-1:0] exp;
    int idx;
    int cyc;
    exp = expect_ct(cur_key, m, ev, es);
    @(negedge clk);
    err_vec = ev;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #4;
    check(busy == 1'b1, "R3 busy after start", 64'(busy), 64'd1);
    check(done == 1'b0, "R8 done cleared by start", 64'(done), 64'd0);
    @(negedge clk);
    idx = 0;
    cyc = 0;
    while (idx < N && cyc < 4000) begin
      msg_valid = (idx < R) && (($urandom() % 100) < vprob);
      msg_bit   = (idx < R) ? m[idx] : 1'b0;
      err_bit   = es[idx];
      ct_ready  = (($urandom() % 100) < rprob);
      if (poke && cyc == 3) begin
        start = 1'b1; key_load = 1'b1; key_in = ~cur_key; err_vec = ~ev;
      end else begin
        start = 1'b0; key_load = 1'b0;
      end
      #4;
      if (ct_valid) begin
        if (idx < R)
          check(ct_bit == exp[idx], "R4/R7 systematic bit", 64'(ct_bit), 64'(exp[idx]));
        else
          check(ct_bit == exp[idx], "R5/R7 redundancy bit", 64'(ct_bit), 64'(exp[idx]));
        check(ct_first == (idx == 0), "R3 first marker", 64'(ct_first), 64'(idx == 0));
        check(ct_last == (idx == N - 1), "R8 last marker", 64'(ct_last), 64'(idx == N - 1));
      end
      if (idx < R)
        check(msg_ready == ct_ready, "R4 ready follows downstream", 64'(msg_ready), 64'(ct_ready));
      else
        check(ct_valid == 1'b1, "R6 redundancy held valid", 64'(ct_valid), 64'd1);
      if (poke && cyc == 3)
        check(busy == 1'b1, "R9 start while busy", 64'(busy), 64'd1);
      if (ct_valid && ct_ready) idx++;
      cyc++;
      @(negedge clk);
    end
    msg_valid = 1'b0; ct_ready = 1'b0; start = 1'b0; key_load = 1'b0; err_bit = 1'b0;
    #4;
    check(done == 1'b1 && busy == 1'b0, "R8 done after last beat",
          64'({done, busy}), 64'b10);
    cycles = cyc;
  endtask

  initial begin
    int cyc;
    void'($urandom(32'd4242));
    rst_n = 1'b0; key_load = 1'b0; key_in = '0; start = 1'b0; err_vec = '0;
    msg_valid = 1'b0; msg_bit = 1'b0; err_bit = 1'b0; ct_ready = 1'b0;
    cur_key = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #4;
    check(busy == 0 && done == 0 && ct_valid == 0 && msg_ready == 0, "R1 reset state",
          64'({busy, done, ct_valid, msg_ready}), 64'd0);

    load_key(R'(13'h1A35));
    run_msg('0, '0, '0, 100, 100, 1'b0, cyc);
    run_msg(R'(1), '0, '0, 100, 100, 1'b0, cyc);
    check(cyc == N, "R10 full-rate cycles", 64'(cyc), 64'(N));
    run_msg(R'(1) << (R - 1), '0, '0, 100, 100, 1'b0, cyc);
    run_msg('1, '0, '0, 80, 90, 1'b0, cyc);
    run_msg(rnd_r(), rnd_n(), '0, 70, 60, 1'b0, cyc);
    run_msg(rnd_r(), '0, rnd_n(), 60, 70, 1'b0, cyc);
    run_msg(rnd_r(), rnd_n(), rnd_n(), 75, 50, 1'b1, cyc);
    run_msg(R'(1), '0, '0, 100, 100, 1'b0, cyc);

    repeat (4) @(negedge clk);
    #4;
    check(done == 1'b1, "R8 done held while idle", 64'(done), 64'd1);

    load_key(rnd_r());
    run_msg(R'(2), '0, '0, 100, 100, 1'b0, cyc);
    for (int t = 0; t < 8; t++) begin
      int vp;
      int rp;
      vp = 40 + int'($urandom() % 61);
      rp = 40 + int'($urandom() % 61);
      run_msg(rnd_r(), rnd_n(), rnd_n(), vp, rp, (t == 3), cyc);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule